// File: doc/BRIEF.md
# Hot-Swap Power Sequencing Controller

This block is the digital sequencer for a hot-swap pass switch on a backplane supply. Comparator flags for supply health and a set of control pins come in. The block waits until the supply has stayed healthy for a complete start-up delay. It then enables the gate drive once an ON request is present. The request can come from the ON pin or from a register ON bit.

Once the switch reports that it is fully enhanced, two active-low power-good outputs are released one after the other. These outputs let two downstream loads start in turn. A third, longer window follows. Before that window ends, a downstream supervisor must confirm power-good on an active-low input, or the switch is turned off and a power-bad fault is logged.

Every delay is counted in pulses of a clock-enable tick, in multiples of the parameter TD_TICKS (written tD below). A single counter times each phase and is cleared at every phase change. Every asynchronous pin and comparator input passes through a two-flop synchronizer first. The register ON bit and the fault-clear strobe are already synchronous and are used directly.

Top module: `hsw_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, gate_en_o is 0, ss_rst_o is 1, both power-good outputs are 1 and fault_o is 0.
- R2: With tick_en_i held high, the gate enables on the (tD+3)th rising edge after the last supply violation clears, provided the ON pin is already high. A supply violation is disable high, overvoltage, input lockout, or both undervoltage flags low. Any violation during the delay restarts it in full.
- R3: If no ON request is present when the start-up delay ends, the gate stays off. It enables on the next edge after the register ON bit is set, or on the third edge after the ON pin rises.
- R4: Each pin and comparator input acts through two synchronizer flops. A pin change therefore takes effect at the FSM on the third rising edge after it is applied.
- R5: After the gate is enabled, staging starts only once both the drain-source-low and gate-high flags are seen high. pg1_n_o falls 2·tD+1 ticked cycles after that.
- R6: pg2_n_o falls exactly 2·tD+1 cycles after pg1_n_o falls, with ticks every cycle.
- R7: A low ext_pg_n_i inside the 4·tD window after pg2_n_o falls keeps the gate on. Without it, the gate turns off 4·tD+1 cycles after pg2_n_o falls, fault_o[3] (power bad) is set, and both power-good outputs return high.
- R8: While the gate is on, any of these turns it off and asserts ss_rst_o on the third edge: disable high, overvoltage, input lockout, both undervoltage flags low, or no ON request. Clearing the register ON bit with the pin low turns the gate off on the next edge. Only one undervoltage flag low has no effect.
- R9: Both power-good outputs return high on every turn-off cause except overvoltage. During an overvoltage turn-off they stay low.
- R10: The fault bits are fault_o[0] undervoltage, [1] overvoltage, [2] input lockout and [3] power bad. A bit is logged only when its condition turns off an enabled gate. It stays set until a one-cycle flt_clr_i pulse clears all bits on the next edge.
- R11: All delay counting advances only on cycles with tick_en_i high. With ticks held off the gate never enables. Once ticks resume, the gate enables tD+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Timing tick, one cycle per delay unit |
| uvl_ok_i | input | 1 | Low undervoltage comparator, 1 = above threshold |
| uvh_ok_i | input | 1 | High undervoltage comparator, 1 = above threshold |
| ov_i | input | 1 | Overvoltage comparator, 1 = fault |
| vin_lo_i | input | 1 | Input supply lockout, 1 = fault |
| on_pin_i | input | 1 | ON pin, 1 = request on |
| off_pin_i | input | 1 | Disable pin, active high |
| ctrl_on_i | input | 1 | Register ON bit (control register bit 3) |
| vds_low_i | input | 1 | Pass switch drain-source voltage low |
| gate_hi_i | input | 1 | Gate voltage high |
| ext_pg_n_i | input | 1 | Downstream power-good confirmation, active low |
| flt_clr_i | input | 1 | Fault register clear strobe |
| gate_en_o | output | 1 | Gate drive enable |
| ss_rst_o | output | 1 | Soft-start reset, 1 = discharge |
| pg1_n_o | output | 1 | First power-good output, active low |
| pg2_n_o | output | 1 | Second power-good output, active low |
| fault_o | output | 4 | Sticky fault bits |

## Verification
A wrong phase state or a mis-cleared counter shows up at the ports as a shift in edge count. It can make the gate rise early or late, or make a power-good output fall out of order, so the bench measures each transition to the exact cycle rather than only checking the final level. A lost synchronizer stage or a skipped counter clear moves a transition by one or more cycles, and that is visible within one phase. A wrong power-good retention or fault-logging decision becomes visible on the edge the gate turns off, so every turn-off cause is swept one at a time.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_READY = 3'd1,
        ST_ON    = 3'd2,
        ST_PG1   = 3'd3,
        ST_PG2   = 3'd4,
        ST_PGI   = 3'd5,
        ST_RUN   = 3'd6
    } hsw_state_e;

    localparam int FLT_W    = 4;
    localparam int FLT_UV   = 0;
    localparam int FLT_OV   = 1;
    localparam int FLT_VLO  = 2;
    localparam int FLT_PBAD = 3;

    typedef struct packed {
        logic uvl;
        logic uvh;
        logic ov;
        logic vlo;
        logic on;
        logic off;
        logic vds;
        logic ghi;
        logic epg_n;
    } hsw_pins_t;

    typedef struct packed {
        hsw_state_e       state;
        logic             gate;
        logic             pg1;
        logic             pg2;
        logic [FLT_W-1:0] flt;
    } hsw_regs_t;

    function automatic logic hsw_is_active(hsw_state_e s);
        return (s == ST_ON) || (s == ST_PG1) || (s == ST_PG2) ||
               (s == ST_PGI) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] st_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] st_d;
        if (g == 0) begin : g_first
            always_comb st_d = d_i;
        end else begin : g_next
            always_comb st_d = st_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[g] <= '0;
            else        st_q[g] <= st_d;
        end
    end

    assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/hsw_tick_timer.sv
module hsw_tick_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (tick_i && (cnt_q < limit_i))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q >= limit_i);

    // R11: count saturates at the active window length
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit_i);

    // R11: without a tick and without a clear the count holds
    a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/hsw_seq_ctrl.sv
module hsw_seq_ctrl
    import hsw_pkg::*;
#(
    parameter int TD_TICKS    = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en_i,
    input  logic             uvl_ok_i,
    input  logic             uvh_ok_i,
    input  logic             ov_i,
    input  logic             vin_lo_i,
    input  logic             on_pin_i,
    input  logic             off_pin_i,
    input  logic             ctrl_on_i,
    input  logic             vds_low_i,
    input  logic             gate_hi_i,
    input  logic             ext_pg_n_i,
    input  logic             flt_clr_i,
    output logic             gate_en_o,
    output logic             ss_rst_o,
    output logic             pg1_n_o,
    output logic             pg2_n_o,
    output logic [FLT_W-1:0] fault_o
);

    localparam int CW = $clog2(4 * TD_TICKS + 1);
    localparam int PW = $bits(hsw_pins_t);
    localparam logic [CW-1:0] LIM_TD  = CW'(TD_TICKS);
    localparam logic [CW-1:0] LIM_2TD = CW'(2 * TD_TICKS);
    localparam logic [CW-1:0] LIM_4TD = CW'(4 * TD_TICKS);

    hsw_pins_t      pin_raw, pin_s;
    logic [PW-1:0]  pin_raw_vec, pin_s_vec;

    always_comb begin
        pin_raw.uvl   = uvl_ok_i;
        pin_raw.uvh   = uvh_ok_i;
        pin_raw.ov    = ov_i;
        pin_raw.vlo   = vin_lo_i;
        pin_raw.on    = on_pin_i;
        pin_raw.off   = off_pin_i;
        pin_raw.vds   = vds_low_i;
        pin_raw.ghi   = gate_hi_i;
        pin_raw.epg_n = ext_pg_n_i;
    end

    assign pin_raw_vec = pin_raw;

    hsw_sync #(
        .WIDTH (PW),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_raw_vec),
        .q_o  (pin_s_vec)
    );

    assign pin_s = hsw_pins_t'(pin_s_vec);

    hsw_regs_t        r_d, r_q;
    logic             tmr_clr, tmr_done, restart;
    logic [CW-1:0]    tmr_lim;
    logic             uv_low, sup_ok, on_req, kill, drop_pg;
    logic [FLT_W-1:0] flt_set;

    hsw_tick_timer #(
        .CW(CW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_i (tick_en_i),
        .limit_i(tmr_lim),
        .done_o (tmr_done)
    );

    always_comb begin
        uv_low  = !pin_s.uvl && !pin_s.uvh;
        sup_ok  = !uv_low && !pin_s.ov && !pin_s.vlo && !pin_s.off;
        on_req  = pin_s.on || ctrl_on_i;
        kill    = r_q.gate && (!sup_ok || !on_req);
        drop_pg = (uv_low || pin_s.off || pin_s.vlo || !on_req) && !pin_s.ov;

        r_d     = r_q;
        flt_set = '0;
        restart = 1'b0;

        unique case (r_q.state)
            ST_WAIT: begin
                if (!sup_ok)       restart   = 1'b1;
                else if (tmr_done) r_d.state = on_req ? ST_ON : ST_READY;
            end
            ST_READY: begin
                if (!sup_ok)      r_d.state = ST_WAIT;
                else if (on_req)  r_d.state = ST_ON;
            end
            ST_ON: begin
                if (!kill && pin_s.vds && pin_s.ghi) r_d.state = ST_PG1;
            end
            ST_PG1: begin
                if (!kill && tmr_done) begin
                    r_d.pg1   = 1'b1;
                    r_d.state = ST_PG2;
                end
            end
            ST_PG2: begin
                if (!kill && tmr_done) begin
                    r_d.pg2   = 1'b1;
                    r_d.state = ST_PGI;
                end
            end
            ST_PGI: begin
                if (!kill) begin
                    if (!pin_s.epg_n) begin
                        r_d.state = ST_RUN;
                    end else if (tmr_done) begin
                        flt_set[FLT_PBAD] = 1'b1;
                        r_d.pg1           = 1'b0;
                        r_d.pg2           = 1'b0;
                        r_d.state         = ST_WAIT;
                    end
                end
            end
            ST_RUN: ;
            default: r_d.state = ST_WAIT;
        endcase

        if (kill) begin
            r_d.state        = ST_WAIT;
            flt_set[FLT_UV]  = uv_low;
            flt_set[FLT_OV]  = pin_s.ov;
            flt_set[FLT_VLO] = pin_s.vlo;
        end

        if (drop_pg) begin
            r_d.pg1 = 1'b0;
            r_d.pg2 = 1'b0;
        end

        r_d.gate = hsw_is_active(r_d.state);
        r_d.flt  = (r_q.flt & ~{FLT_W{flt_clr_i}}) | flt_set;

        tmr_clr = restart || (r_d.state != r_q.state);

        case (r_q.state)
            ST_WAIT:         tmr_lim = LIM_TD;
            ST_PG1, ST_PG2:  tmr_lim = LIM_2TD;
            default:         tmr_lim = LIM_4TD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_WAIT;
            r_q.gate  <= 1'b0;
            r_q.pg1   <= 1'b0;
            r_q.pg2   <= 1'b0;
            r_q.flt   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_en_o = r_q.gate;
    assign ss_rst_o  = !r_q.gate;
    assign pg1_n_o   = !r_q.pg1;
    assign pg2_n_o   = !r_q.pg2;
    assign fault_o   = r_q.flt;

    // R2: the gate only rises after a healthy supply with an ON request
    a_r2_gate_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.gate) |-> $past(sup_ok && on_req));

    // R8: any turn-off cause with the gate on removes the gate next cycle
    a_r8_kill_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.gate && (!sup_ok || !on_req)) |=> !r_q.gate);

    // R5: first power-good only asserts with the gate on
    a_r5_pg1_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pg1) |-> r_q.gate);

    // R6: second power-good never ahead of the first
    a_r6_pg_order: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pg2 |-> r_q.pg1);

    // R9: overvoltage never releases power-good
    a_r9_ov_keeps_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pg1 && pin_s.ov) |=> r_q.pg1);

    // R10: without a clear strobe no fault bit is lost
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_clr_i |=> ((r_q.flt & $past(r_q.flt)) == $past(r_q.flt)));

    // R10: a clear while the gate is off empties the fault bits
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clr_i && !r_q.gate) |=> (r_q.flt == '0));

endmodule

// File: tb/tb_hsw_seq_ctrl.sv
module tb_hsw_seq_ctrl;

    localparam int TD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, uvl = 1'b1, uvh = 1'b1, ov = 1'b0, vlo = 1'b0;
    logic on_p = 1'b1, off_p = 1'b1, ctrl = 1'b0, vds = 1'b1, ghi = 1'b1;
    logic epg_n = 1'b1, clr = 1'b0;
    logic gate, ssr, pg1_n, pg2_n;
    logic [3:0] flt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hsw_seq_ctrl #(.TD_TICKS(TD), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick),
        .uvl_ok_i(uvl), .uvh_ok_i(uvh), .ov_i(ov), .vin_lo_i(vlo),
        .on_pin_i(on_p), .off_pin_i(off_p), .ctrl_on_i(ctrl),
        .vds_low_i(vds), .gate_hi_i(ghi), .ext_pg_n_i(epg_n),
        .flt_clr_i(clr), .gate_en_o(gate), .ss_rst_o(ssr),
        .pg1_n_o(pg1_n), .pg2_n_o(pg2_n), .fault_o(flt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0:       return gate;
            1:       return pg1_n;
            default: return pg2_n;
        endcase
    endfunction

    task automatic wait_for(input int sel, input logic val, input int maxn, output int n);
        n = -1;
        for (int i = 1; i <= maxn; i++) begin
            step();
            if (sig(sel) == val) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic cleanup(input logic on_v, input logic ctrl_v);
        off_p = 1'b1; ov = 1'b0; vlo = 1'b0; uvl = 1'b1; uvh = 1'b1;
        vds = 1'b1; ghi = 1'b1; tick = 1'b1;
        repeat (4) step();
        clr = 1'b1; step(); clr = 1'b0;
        on_p = on_v; ctrl = ctrl_v;
        step();
    endtask

    task automatic bring_up(input logic on_v, input logic ctrl_v);
        int n;
        cleanup(on_v, ctrl_v);
        epg_n = 1'b0;
        off_p = 1'b0;
        wait_for(2, 1'b0, 200, n);
        repeat (3) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        repeat (3) step();
        // R1 reset state while in reset
        chk("R1 gate in reset", gate, 0);
        chk("R1 ss_rst in reset", ssr, 1);
        rst_n = 1'b1;
        chk("R1 pg1_n after reset", pg1_n, 1);
        chk("R1 pg2_n after reset", pg2_n, 1);
        chk("R1 fault after reset", flt, 0);
        repeat (4) step();

        // R2 R5 R6 R7: full sequence, no downstream confirmation
        epg_n = 1'b1;
        off_p = 1'b0;
        wait_for(0, 1'b1, 100, n);
        chk("R2 startup delay edges", n, TD + 3);
        chk("R8 ss_rst released with gate", ssr, 0);
        wait_for(1, 1'b0, 100, n);
        chk("R5 pg1 delay", n, 2 * TD + 2);
        wait_for(2, 1'b0, 100, n);
        chk("R6 pg2 delay", n, 2 * TD + 1);
        wait_for(0, 1'b0, 100, n);
        chk("R7 power-bad turn-off delay", n, 4 * TD + 1);
        chk("R7 power-bad bit3", flt, 8);
        chk("R7 pg1_n high after power bad", pg1_n, 1);
        chk("R7 pg2_n high after power bad", pg2_n, 1);

        // R2: violation sweep during the start-up delay
        for (int j = 1; j <= TD; j++) begin
            cleanup(1'b1, 1'b0);
            off_p = 1'b0;
            repeat (j) step();
            vlo = 1'b1;
            step();
            vlo = 1'b0;
            wait_for(0, 1'b1, 100, n);
            chk($sformatf("R2 restart after violation at %0d", j), n, TD + 3);
            chk("R10 no log while gate off", flt, 0);
        end

        // R3: register ON bit and late ON pin
        cleanup(1'b0, 1'b0);
        off_p = 1'b0;
        repeat (20) step();
        chk("R3 gate off without ON request", gate, 0);
        ctrl = 1'b1;
        wait_for(0, 1'b1, 20, n);
        chk("R3 register ON bit latency", n, 1);
        ctrl = 1'b0;
        wait_for(0, 1'b0, 20, n);
        chk("R8 register ON bit clear latency", n, 1);
        chk("R10 ON clear not logged", flt, 0);
        repeat (20) step();
        chk("R3 gate stays off in ready", gate, 0);
        on_p = 1'b1;
        wait_for(0, 1'b1, 20, n);
        chk("R3 R4 ON pin latency", n, 3);

        // R11: no ticks, then ticks resume
        cleanup(1'b1, 1'b0);
        tick = 1'b0;
        off_p = 1'b0;
        repeat (40) step();
        chk("R11 gate held without ticks", gate, 0);
        tick = 1'b1;
        wait_for(0, 1'b1, 20, n);
        chk("R11 delay after ticks resume", n, TD + 1);

        // R5: staging waits for switch status flags
        cleanup(1'b1, 1'b0);
        vds = 1'b0;
        off_p = 1'b0;
        wait_for(0, 1'b1, 100, n);
        repeat (30) step();
        chk("R5 pg1 held until vds low", pg1_n, 1);
        vds = 1'b1;
        wait_for(1, 1'b0, 100, n);
        chk("R5 pg1 after status flags", n, 2 * TD + 4);

        // R7: confirmation keeps the gate on
        bring_up(1'b1, 1'b0);
        repeat (4 * TD + 10) step();
        chk("R7 gate kept on with confirmation", gate, 1);
        chk("R7 no fault with confirmation", flt, 0);
        chk("R6 pg2 low in run", pg2_n, 0);

        // R8 R9 R10: turn-off cause sweep from the running state
        for (int c = 0; c < 6; c++) begin
            int exp_lat, exp_pg, exp_flt;
            bring_up(c != 5, c == 5);
            exp_lat = (c == 5) ? 1 : 3;
            exp_pg  = (c == 1) ? 0 : 1;
            exp_flt = (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 1 : 0;
            if (c == 3) begin
                uvl = 1'b0;
                repeat (6) step();
                chk("R8 single UV flag ignored", gate, 1);
                uvl = 1'b1;
                repeat (3) step();
            end
            case (c)
                0: off_p = 1'b1;
                1: ov = 1'b1;
                2: vlo = 1'b1;
                3: begin uvl = 1'b0; uvh = 1'b0; end
                4: on_p = 1'b0;
                default: ctrl = 1'b0;
            endcase
            wait_for(0, 1'b0, 20, n);
            chk($sformatf("R8 R4 turn-off latency cause %0d", c), n, exp_lat);
            chk($sformatf("R8 ss_rst cause %0d", c), ssr, 1);
            chk($sformatf("R9 pg1_n cause %0d", c), pg1_n, exp_pg);
            chk($sformatf("R9 pg2_n cause %0d", c), pg2_n, exp_pg);
            chk($sformatf("R10 fault bits cause %0d", c), flt, exp_flt);
            repeat (5) step();
            chk($sformatf("R10 fault sticky cause %0d", c), flt, exp_flt);
            clr = 1'b1;
            step();
            clr = 1'b0;
            chk($sformatf("R10 fault cleared cause %0d", c), flt, 0);
            if (c == 1) begin
                chk("R9 pg kept during overvoltage", pg1_n, 0);
                cleanup(1'b1, 1'b0);
                chk("R9 pg released by later disable", pg1_n, 1);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule